// File: doc/BRIEF.md
# Boot Flash Write-Protect Lock Controller

This block guards write access to a boot flash device. Software reaches it through a small register port. One control byte holds a write-enable bit, a lock bit and a privileged-only bypass bit. A second register holds a global interrupt-enable bit, and a third holds an interrupt-lock bit. The block drives a flash write-permit output. When software tries to turn write-enable on while the lock is armed and interrupts are globally enabled, the block does not set the bit. It emits a one-cycle privileged-mode interrupt instead, and the privileged handler decides what happens next.

The lock bit and the interrupt-lock bit can only be set; reset is the only way to clear them. A privileged-mode input marks accesses made by the handler. It allows write-enable to be cleared under lock, and it satisfies the bypass condition for the write permit. A power-on strap is sampled once, on the first clock after reset is released. Its level is reported in a status register and drives a region-override output.

Top module: `fw_wp_lock`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `flash_wr_ok_o` is 0.
- R2: The control register is at address 0. Bit 0 is write-enable, bit 1 is lock and bit 5 is bypass, and all other bits read 0. While lock is 0, write-enable follows each written value.
- R3: A write to the control register can set the lock bit but can never clear it. Only reset clears it.
- R4: With lock=1 and global interrupt-enable=1, writing 1 to write-enable while it is 0 leaves it at 0. `irq_o` is then high for exactly the one cycle after the write edge.
- R5: With lock=1 and global interrupt-enable=0, writing 1 to write-enable sets it, and no interrupt is raised.
- R6: With lock=1, a write of 0 to write-enable is ignored unless `priv_i` is 1 during that write.
- R7: Writing 1 to write-enable while it is already 1 raises no interrupt.
- R8: `flash_wr_ok_o` equals write-enable AND (NOT bypass OR `priv_i`).
- R9: The interrupt-enable register is at address 1, with global interrupt-enable at bit 0. While interrupt-lock is 0, it reads back the last value written.
- R10: The interrupt-lock register is at address 2, bit 0. It can be set but never cleared by a write. While it is 1, writes to address 1 are ignored.
- R11: On the first clock after reset release, `strap_n_i` is captured. The status register at address 3 reports the captured level in bit 13. `region_rw_all_o` is 1 only when that captured level is 0. Later changes on the strap have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| priv_i | input | 1 | Privileged-mode indicator |
| strap_n_i | input | 1 | Power-on strap, low grants full region access |
| irq_o | output | 1 | Privileged-mode interrupt pulse |
| flash_wr_ok_o | output | 1 | Flash write permit |
| region_rw_all_o | output | 1 | Strap-granted read-write access to all regions |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 2-bit addresses and a 16-bit status register with the strap at bit 13. At these values the whole register map is reachable, and so is every combination of lock, interrupt-enable, interrupt-lock and privilege that the trap decision depends on. Two resets are applied, one with the strap high and one with it low, so that both capture outcomes are covered and the set-only bits are shown to clear only through reset.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_IEN  = 1;
  localparam int unsigned ADDR_ILK  = 2;
  localparam int unsigned ADDR_STAT = 3;

  localparam int unsigned WE_BIT   = 0;
  localparam int unsigned LOCK_BIT = 1;
  localparam int unsigned BYP_BIT  = 5;
  localparam int unsigned GIE_BIT  = 0;
  localparam int unsigned ILK_BIT  = 0;
  localparam int unsigned CTRL_W   = 8;

  typedef struct packed {
    logic byp;
    logic lock;
    logic we;
  } wp_ctrl_t;
endpackage

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg
  import wp_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              priv_i,
  input  logic              gie_i,
  output wp_ctrl_t          ctrl_o,
  output logic              irq_o
);
  wp_ctrl_t ctrl_q, ctrl_d;
  logic     irq_q;
  logic     trap;

  // set attempt under armed lock with interrupts live becomes a trap
  assign trap = wr_i & wdata_i[WE_BIT] & ~ctrl_q.we & ctrl_q.lock & gie_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d.lock = ctrl_q.lock | wdata_i[LOCK_BIT];
      ctrl_d.byp  = wdata_i[BYP_BIT];
      if (wdata_i[WE_BIT]) begin
        ctrl_d.we = ctrl_q.we | ~(ctrl_q.lock & gie_i);
      end else if (!ctrl_q.lock || priv_i) begin
        ctrl_d.we = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= trap;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/wp_ien_reg.sv
module wp_ien_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ien_wr_i,
  input  logic ilk_wr_i,
  input  logic gie_bit_i,
  input  logic ilk_bit_i,
  output logic gie_o,
  output logic ilock_o
);
  logic gie_q, ilock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      ilock_q <= 1'b0;
    end else begin
      if (ien_wr_i && !ilock_q) gie_q <= gie_bit_i;
      if (ilk_wr_i) ilock_q <= ilock_q | ilk_bit_i;
    end
  end

  assign gie_o   = gie_q;
  assign ilock_o = ilock_q;
endmodule

// File: rtl/wp_strap_cap.sv
module wp_strap_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_n_i,
  output logic strap_o,
  output logic valid_o
);
  logic strap_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      strap_q <= strap_n_i;
      valid_q <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fw_wp_lock.sv
module fw_wp_lock
  import wp_lock_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned STRAP_BIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              priv_i,
  input  logic              strap_n_i,
  output logic              irq_o,
  output logic              flash_wr_ok_o,
  output logic              region_rw_all_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [NREG-1:0] sel;
  wp_ctrl_t        ctrl;
  logic            gie, ilock;
  logic            strap_q, strap_valid;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CTRL_W];

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign sel[g] = reg_wr_i && (reg_addr_i == ADDR_W'(g));
  end

  wp_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel[ADDR_CTRL]),
    .wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .priv_i  (priv_i),
    .gie_i   (gie),
    .ctrl_o  (ctrl),
    .irq_o   (irq_o)
  );

  wp_ien_reg u_ien (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ien_wr_i  (sel[ADDR_IEN]),
    .ilk_wr_i  (sel[ADDR_ILK]),
    .gie_bit_i (reg_wdata_i[GIE_BIT]),
    .ilk_bit_i (reg_wdata_i[ILK_BIT]),
    .gie_o     (gie),
    .ilock_o   (ilock)
  );

  wp_strap_cap u_strap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_n_i (strap_n_i),
    .strap_o   (strap_q),
    .valid_o   (strap_valid)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(ADDR_CTRL): begin
        reg_rdata_o[WE_BIT]   = ctrl.we;
        reg_rdata_o[LOCK_BIT] = ctrl.lock;
        reg_rdata_o[BYP_BIT]  = ctrl.byp;
      end
      ADDR_W'(ADDR_IEN):  reg_rdata_o[GIE_BIT] = gie;
      ADDR_W'(ADDR_ILK):  reg_rdata_o[ILK_BIT] = ilock;
      default:            reg_rdata_o[STRAP_BIT] = strap_q;
    endcase
  end

  assign flash_wr_ok_o   = ctrl.we & (~ctrl.byp | priv_i);
  assign region_rw_all_o = strap_valid & ~strap_q;
endmodule

// File: rtl/wp_lock_chk.sv
module wp_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic we_i,
  input logic lock_i,
  input logic byp_i,
  input logic gie_i,
  input logic ilock_i,
  input logic priv_i,
  input logic irq_i,
  input logic permit_i,
  input logic strap_i,
  input logic strap_valid_i
);
  // R3
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  // R10
  ilock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilock_i |=> ilock_i);

  // R10
  gie_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilock_i |=> $stable(gie_i));

  // R4
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (lock_i && gie_i && !we_i));

  // R6
  locked_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && we_i && !priv_i) |=> we_i);

  // R8
  permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_i |-> (we_i && (!byp_i || priv_i)));

  // R11
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_valid_i |=> (strap_valid_i && $stable(strap_i)));
endmodule

bind fw_wp_lock wp_lock_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (ctrl.we),
  .lock_i        (ctrl.lock),
  .byp_i         (ctrl.byp),
  .gie_i         (gie),
  .ilock_i       (ilock),
  .priv_i        (priv_i),
  .irq_i         (irq_o),
  .permit_i      (flash_wr_ok_o),
  .strap_i       (strap_q),
  .strap_valid_i (strap_valid)
);

// File: tb/tb_fw_wp_lock.sv
module tb_fw_wp_lock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        priv = 1'b0;
  logic        strap_n = 1'b1;
  logic        irq, permit, region;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_we, m_lock, m_byp, m_gie, m_ilock, m_irq, m_strap, m_cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_wp_lock dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .reg_wr_i        (wr),
    .reg_addr_i      (addr),
    .reg_wdata_i     (wdata),
    .reg_rdata_o     (rdata),
    .priv_i          (priv),
    .strap_n_i       (strap_n),
    .irq_o           (irq),
    .flash_wr_ok_o   (permit),
    .region_rw_all_o (region)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_we <= 0; m_lock <= 0; m_byp <= 0; m_gie <= 0;
      m_ilock <= 0; m_irq <= 0; m_strap <= 0; m_cap <= 0;
    end else begin
      m_irq <= 0;
      if (!m_cap) begin
        m_cap <= 1;
        m_strap <= strap_n;
      end
      if (wr) begin
        case (addr)
          2'd0: begin
            if (wdata[1]) m_lock <= 1;
            m_byp <= wdata[5];
            if (wdata[0]) begin
              if (!m_we) begin
                if (m_lock && m_gie) m_irq <= 1;
                else m_we <= 1;
              end
            end else if (!m_lock || priv) begin
              m_we <= 0;
            end
          end
          2'd1: if (!m_ilock) m_gie <= wdata[0];
          2'd2: if (wdata[0]) m_ilock <= 1;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[0] = m_we; v[1] = m_lock; v[5] = m_byp; end
      2'd1: v[0] = m_gie;
      2'd2: v[0] = m_ilock;
      default: v[13] = m_strap;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R8 permit", {31'b0, permit}, {31'b0, m_we & (~m_byp | priv)});
      chk("R11 region", {31'b0, region}, {31'b0, m_cap & ~m_strap});
      chk("R2 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic do_reset(input logic s);
    strap_n = s;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input logic p);
    @(posedge clk);
    #1 wr = 1'b1; addr = a; wdata = d; priv = p;
    @(posedge clk);
    #1 wr = 1'b0; priv = 1'b0;
  endtask

  task automatic rd_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R1 reset state
    rd_reg("R1 ctrl", 2'd0, 32'h0);
    rd_reg("R1 ien", 2'd1, 32'h0);
    rd_reg("R1 ilk", 2'd2, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 permit", {31'b0, permit}, 32'h0);
    // R11 strap high captured
    rd_reg("R11 status", 2'd3, 32'h0000_2000);
    chk("R11 region", {31'b0, region}, 32'h0);

    // R2 free write-enable while unlocked
    wr_reg(2'd0, 32'h1, 1'b0);
    rd_reg("R2 set", 2'd0, 32'h1);
    chk("R2 permit", {31'b0, permit}, 32'h1);
    wr_reg(2'd0, 32'hFFFF_FF00, 1'b0);
    rd_reg("R2 clear", 2'd0, 32'h0);

    // R8 bypass needs privilege
    wr_reg(2'd0, 32'h21, 1'b0);
    rd_reg("R8 ctrl", 2'd0, 32'h21);
    chk("R8 no priv", {31'b0, permit}, 32'h0);
    priv = 1'b1;
    #1 chk("R8 priv", {31'b0, permit}, 32'h1);
    priv = 1'b0;
    wr_reg(2'd0, 32'h0, 1'b0);

    // R9 global interrupt-enable
    wr_reg(2'd1, 32'h1, 1'b0);
    rd_reg("R9 set", 2'd1, 32'h1);
    wr_reg(2'd1, 32'h0, 1'b0);
    rd_reg("R9 clear", 2'd1, 32'h0);
    wr_reg(2'd1, 32'h1, 1'b0);

    // R3 lock set-only
    wr_reg(2'd0, 32'h2, 1'b0);
    wr_reg(2'd0, 32'h0, 1'b0);
    rd_reg("R3 sticky", 2'd0, 32'h2);

    // R4 trap under lock with interrupts enabled
    wr_reg(2'd0, 32'h3, 1'b0);
    chk("R4 irq high", {31'b0, irq}, 32'h1);
    rd_reg("R4 we held", 2'd0, 32'h2);
    @(posedge clk); #1;
    chk("R4 irq low", {31'b0, irq}, 32'h0);

    // R5 interrupts disabled: write goes through
    wr_reg(2'd1, 32'h0, 1'b0);
    wr_reg(2'd0, 32'h3, 1'b0);
    chk("R5 no irq", {31'b0, irq}, 32'h0);
    rd_reg("R5 we set", 2'd0, 32'h3);

    // R7 no re-trigger while already set
    wr_reg(2'd1, 32'h1, 1'b0);
    wr_reg(2'd0, 32'h3, 1'b0);
    chk("R7 no irq", {31'b0, irq}, 32'h0);

    // R6 clear under lock needs privilege
    wr_reg(2'd0, 32'h2, 1'b0);
    rd_reg("R6 ignored", 2'd0, 32'h3);
    wr_reg(2'd0, 32'h2, 1'b1);
    rd_reg("R6 priv clear", 2'd0, 32'h2);

    // R10 interrupt lock
    wr_reg(2'd2, 32'h1, 1'b0);
    wr_reg(2'd1, 32'h0, 1'b0);
    rd_reg("R10 gie frozen", 2'd1, 32'h1);
    wr_reg(2'd2, 32'h0, 1'b0);
    rd_reg("R10 sticky", 2'd2, 32'h1);

    // R11 strap low, second reset; R1 locks cleared by reset
    do_reset(1'b0);
    rd_reg("R1 lock cleared", 2'd0, 32'h0);
    rd_reg("R1 ilock cleared", 2'd2, 32'h0);
    rd_reg("R11 status low", 2'd3, 32'h0);
    chk("R11 region high", {31'b0, region}, 32'h1);
    strap_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rd_reg("R11 no resample", 2'd3, 32'h0);
    chk("R11 region held", {31'b0, region}, 32'h1);

    repeat (2) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule